// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable single-port static memory with 32-bit words, built from four 8-bit lanes. Every control and data input is captured on the rising clock edge. A read returns its word one pipeline stage after the address is captured. A write can update any subset of the four lanes, or all four at once through a global override. Three chip selects must all be active before an access takes place, so several instances can share one address and data bus for depth expansion.

The read data leaves on its own output bus, with a drive flag beside it. The flag models the enable of a shared three-state bus. An asynchronous output-enable input gates that drive without waiting for the clock. A sleep input puts the memory into power-down. After sleep falls, a fixed wake-up window must pass before any access is accepted. Memory contents are kept through sleep and through every access that is ignored.

Burst address generation is not part of the block; the caller presents every address. The depth is set by the address-width parameter. The full-size part uses 16 address bits, and the default is smaller so that elaboration stays light. The ports are plain bus pins with no handshake, because a memory bus of this kind never stalls.

Top module: `ssram_pipe`

## Requirements
- R1: With `lane_wr_en_n` low and `wr_all_n` high, a selected access writes each lane whose `lane_wr_n` bit is low and leaves the other lanes unchanged. Bit `i` of `lane_wr_n` controls data bits `8*i+7 : 8*i`, so bit 0 controls bits 7:0 and bit 3 controls bits 31:24.
- R2: With `lane_wr_en_n` high and `wr_all_n` high, the `lane_wr_n` inputs are ignored and a selected access is a read.
- R3: With `wr_all_n` low, a selected access writes all four lanes, whatever `lane_wr_en_n` and `lane_wr_n` hold.
- R4: A read whose address is captured at edge k drives `dout_drv` high and presents the stored word on `dout` after edge k+1, and not before. A write access leaves the output undriven after the following edge. A read on the cycle right after a write to the same address returns the newly written word.
- R5: An access takes place only when `sel_n` is low and both `sel_a` and `sel_b` are high. If any chip select is inactive, the access writes nothing and leaves the output undriven.
- R6: `out_en_n` high forces `dout_drv` low and `dout` to zero at once, without waiting for a clock edge. Returning it low restores the pending read data within the same cycle.
- R7: Any access captured while `sleep` is high is ignored, and `dout_drv` stays low for as long as `sleep` is high.
- R8: After `sleep` is first captured low, the first three rising edges ignore all accesses and the output stays undriven. The fourth edge accepts an access.
- R9: Memory contents survive sleep, the wake-up window, and every ignored access.
- R10: While `rst_n` is low, `dout_drv` is low, `dout` is zero and no wake-up window is pending.
- R11: Whenever `dout_drv` is low, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| sel_n | input | 1 | Chip select, active low |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Qualifier for the per-lane write inputs, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| dout | output | 32 | Read data, zero when not driven |
| dout_drv | output | 1 | High while the data output drives the bus |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives 64 words. The bench then keeps a full shadow copy of the array and can choose addresses at both ends, 0 and 63. The lane count and the three-cycle wake-up window keep their defaults. The bench can therefore hit each ignored edge of the window, and the first accepted edge, with one directed access apiece.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  // What the decode stage decided to do with the access on the current edge
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sleep,
  output acc_kind_e        kind,
  output logic [LANES-1:0] wmask,
  output logic             lock_now
);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic [WAKE_W-1:0] wake_cnt;
  logic              sel_ok;
  logic              wr_req;

  // Counts the edges still locked out after sleep was last seen high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= '0;
    end else if (sleep) begin
      wake_cnt <= WAKE_W'(WAKE_CYC);
    end else if (wake_cnt != '0) begin
      wake_cnt <= wake_cnt - 1'b1;
    end
  end

  assign lock_now = sleep | (wake_cnt != '0);
  assign sel_ok   = ~sel_n & sel_a & sel_b;
  assign wr_req   = ~wr_all_n | ~lane_wr_en_n;

  // The global write overrides the lane strobes; otherwise the qualifier gates them
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wmask[g] = ~wr_all_n | (~lane_wr_en_n & ~lane_wr_n[g]);
  end

  always_comb begin
    if (!sel_ok || lock_now) kind = ACC_IDLE;
    else if (wr_req)         kind = ACC_WRITE;
    else                     kind = ACC_READ;
  end
endmodule

// File: rtl/ssr_array.sv
module ssr_array
  import ssr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  acc_kind_e               kind,
  input  logic [LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  // Lane-masked write on the capturing edge
  always_ff @(posedge clk) begin
    if (kind == ACC_WRITE) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  // Stage one holds the captured read; stage two holds the output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      addr_q <= addr;
      rd_q   <= (kind == ACC_READ);
      rvalid <= rd_q;
      if (rd_q) rdata <= mem[addr_q];
    end
  end
endmodule

// File: rtl/ssr_outdrv.sv
module ssr_outdrv #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic              rvalid,
  input  logic              out_en_n,
  input  logic              lock_now,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drv
);
  // Purely combinational so that the output enable takes effect between edges
  assign dout_drv = rvalid & ~out_en_n & ~lock_now;
  assign dout     = dout_drv ? rdata : '0;
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe
  import ssr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int WAKE_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    sel_a,
  input  logic                    sel_b,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drv
);
  localparam int DATA_W = LANES * LANE_W;

  acc_kind_e         kind;
  logic [LANES-1:0]  wmask;
  logic              lock_now;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;

  ssr_ctrl #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_a(sel_a), .sel_b(sel_b),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .sleep(sleep), .kind(kind), .wmask(wmask), .lock_now(lock_now)
  );

  ssr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wmask(wmask), .addr(addr),
    .wdata(din), .rdata(rdata), .rvalid(rvalid)
  );

  ssr_outdrv #(.DATA_W(DATA_W)) u_out (
    .rdata(rdata), .rvalid(rvalid), .out_en_n(out_en_n), .lock_now(lock_now),
    .dout(dout), .dout_drv(dout_drv)
  );
endmodule

// File: rtl/ssram_pipe_chk.sv
module ssram_pipe_chk #(
  parameter int ADDR_W   = 10,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int WAKE_CYC = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_n,
  input logic                    sel_a,
  input logic                    sel_b,
  input logic [ADDR_W-1:0]       addr,
  input logic [LANES*LANE_W-1:0] din,
  input logic                    wr_all_n,
  input logic                    lane_wr_en_n,
  input logic [LANES-1:0]        lane_wr_n,
  input logic                    out_en_n,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] dout,
  input logic                    dout_drv
);
  localparam int QW = $clog2(WAKE_CYC + 1);

  // Independent count of locked-out edges, seen only from the ports
  logic [QW-1:0] quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            quiet <= '0;
    else if (sleep)        quiet <= QW'(WAKE_CYC);
    else if (quiet != '0)  quiet <= quiet - 1'b1;
  end

  logic sel_ok, rd_go, wr_go;
  assign sel_ok = !sel_n && sel_a && sel_b;
  assign rd_go  = sel_ok && wr_all_n && lane_wr_en_n && !sleep && (quiet == '0);
  assign wr_go  = sel_ok && (!wr_all_n || !lane_wr_en_n) && !sleep && (quiet == '0);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_drv |-> !out_en_n);

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_drv);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drv |-> (dout == '0));

  // R4
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go ##1 !sleep |=> (sleep || (dout_drv == !out_en_n)));

  // R4
  wr_nodrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ##1 !dout_drv);

  // R5
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> ##1 !dout_drv);

  // R8
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet != '0) |=> ##1 !dout_drv);
endmodule

bind ssram_pipe ssram_pipe_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(WAKE_CYC)
) u_chk (.*);

// File: tb/sim_ssram_pipe.sv
module sim_ssram_pipe;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, sel_a = 1'b1, sel_b = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0] din = '0;
  logic        wr_all_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic        out_en_n = 1'b0, sleep = 1'b0;
  logic [31:0] dout;
  logic        dout_drv;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] shadow [64];

  always #4 clk = ~clk;

  ssram_pipe #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_a(sel_a), .sel_b(sel_b),
    .addr(addr), .din(din), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .sleep(sleep),
    .dout(dout), .dout_drv(dout_drv)
  );

  // Vector: {kind[1:0], addr[5:0], lanes_n[3:0], data[31:0]}
  // kind 0 lane write, 1 global write (lane inputs idle), 2 read, 3 read with lane strobes low
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {2'd1, 6'd0,  4'hF, 32'h11223344},
    {2'd1, 6'd1,  4'hF, 32'hA5A5A5A5},
    {2'd1, 6'd5,  4'hF, 32'h00000000},
    {2'd1, 6'd63, 4'hF, 32'hFFFFFFFF},
    {2'd1, 6'd20, 4'hF, 32'h12345678},
    {2'd0, 6'd5,  4'hE, 32'hDEADBEEF},
    {2'd0, 6'd5,  4'h7, 32'hCAFEF00D},
    {2'd2, 6'd5,  4'hF, 32'h0},
    {2'd1, 6'd63, 4'hF, 32'h0BADF00D},
    {2'd2, 6'd63, 4'hF, 32'h0},
    {2'd3, 6'd0,  4'h0, 32'hFFFFFFFF},
    {2'd2, 6'd0,  4'hF, 32'h0},
    {2'd0, 6'd1,  4'h9, 32'h00FFFF00},
    {2'd2, 6'd1,  4'hF, 32'h0},
    {2'd2, 6'd20, 4'hF, 32'h0},
    {2'd0, 6'd63, 4'h0, 32'h55667788}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    sel_n = 1'b1; sel_a = 1'b1; sel_b = 1'b1;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_wr_n = 4'hF;
  endtask

  task automatic shadow_put(input int a, input logic [3:0] lanes_n, input bit global, input logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (global || !lanes_n[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  // One write access on the next edge
  task automatic wr(input int a, input logic [3:0] lanes_n, input bit global, input logic [31:0] d);
    sel_n = 1'b0; sel_a = 1'b1; sel_b = 1'b1;
    addr = AW'(a); din = d;
    wr_all_n = !global;
    lane_wr_en_n = global;
    lane_wr_n = lanes_n;
    tick();
    go_idle();
  endtask

  // Read with latency check; lanes_n is applied with the qualifier high
  task automatic rd_check(input int a, input logic [3:0] lanes_n, input string req);
    sel_n = 1'b0; sel_a = 1'b1; sel_b = 1'b1;
    addr = AW'(a); lane_wr_n = lanes_n;
    tick();
    go_idle();
    check(dout_drv == 1'b0, "R4 early drive", {31'd0, dout_drv}, 32'd0);
    tick();
    check(dout_drv == 1'b1, req, {31'd0, dout_drv}, 32'd1);
    check(dout == shadow[a], req, dout, shadow[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    // R10 reset state
    go_idle();
    tick(); tick();
    check(dout_drv == 1'b0, "R10 drive in reset", {31'd0, dout_drv}, 32'd0);
    check(dout == '0, "R10 data in reset", dout, 32'd0);
    rst_n = 1'b1;
    tick();

    // Table walk: R1, R2, R3
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      int          a;
      logic [3:0]  ln;
      logic [31:0] d;
      k  = VEC[v][43:42];
      a  = int'(VEC[v][41:36]);
      ln = VEC[v][35:32];
      d  = VEC[v][31:0];
      case (k)
        2'd0: begin wr(a, ln, 1'b0, d); shadow_put(a, ln, 1'b0, d); end
        2'd1: begin wr(a, ln, 1'b1, d); shadow_put(a, ln, 1'b1, d); end
        2'd2: rd_check(a, ln, "R1 lane read back");
        default: rd_check(a, ln, "R2 lane strobes ignored");
      endcase
    end
    rd_check(63, 4'hF, "R1 all lanes via strobes");
    // R3: global write while lane qualifier low with no lane strobes
    sel_n = 1'b0; addr = AW'(20); din = 32'h89ABCDEF;
    wr_all_n = 1'b0; lane_wr_en_n = 1'b0; lane_wr_n = 4'hF;
    tick(); go_idle();
    shadow[20] = 32'h89ABCDEF;
    rd_check(20, 4'hF, "R3 global override");

    // R4 write leaves output undriven, and read right after write
    wr(7, 4'hF, 1'b1, 32'h0F0F0F0F); shadow[7] = 32'h0F0F0F0F;
    tick();
    check(dout_drv == 1'b0, "R4 write no drive", {31'd0, dout_drv}, 32'd0);
    wr(7, 4'hD, 1'b0, 32'hAAAAAAAA); shadow_put(7, 4'hD, 1'b0, 32'hAAAAAAAA);
    rd_check(7, 4'hF, "R4 read after write");

    // R6 asynchronous output enable
    sel_n = 1'b0; addr = AW'(1);
    tick(); go_idle(); tick();
    out_en_n = 1'b1; #1;
    check(dout_drv == 1'b0, "R6 oe off drive", {31'd0, dout_drv}, 32'd0);
    check(dout == '0, "R11 oe off data", dout, 32'd0);
    out_en_n = 1'b0; #1;
    check(dout_drv == 1'b1 && dout == shadow[1], "R6 oe on restores", dout, shadow[1]);

    // R5 each chip select inactive: no write, no drive
    for (int s = 0; s < 3; s++) begin
      sel_n = (s == 0); sel_a = (s != 1); sel_b = (s != 2);
      addr = AW'(0); din = 32'hBAD0BAD0; wr_all_n = 1'b0;
      tick(); go_idle();
      sel_n = (s == 0); sel_a = (s != 1); sel_b = (s != 2);
      addr = AW'(0);
      tick(); go_idle(); tick();
      check(dout_drv == 1'b0, "R5 deselected read", {31'd0, dout_drv}, 32'd0);
    end
    rd_check(0, 4'hF, "R5 deselected write ignored");

    // R7 sleep hides a pending read and ignores a write
    sel_n = 1'b0; addr = AW'(1);
    tick(); go_idle();
    sleep = 1'b1;
    tick();
    check(dout_drv == 1'b0, "R7 sleep gates read", {31'd0, dout_drv}, 32'd0);
    wr(1, 4'hF, 1'b1, 32'h0);
    sel_n = 1'b0; addr = AW'(1);
    tick(); go_idle(); tick();
    check(dout_drv == 1'b0, "R7 read during sleep", {31'd0, dout_drv}, 32'd0);

    // R8 three locked edges, then the fourth edge accepted
    sleep = 1'b0;
    wr(0, 4'hF, 1'b1, 32'h0);
    check(dout_drv == 1'b0, "R8 wake window drive", {31'd0, dout_drv}, 32'd0);
    wr(20, 4'hF, 1'b1, 32'h0);
    wr(63, 4'hF, 1'b1, 32'h0);
    wr(5, 4'hF, 1'b1, 32'h55555555); shadow[5] = 32'h55555555;
    rd_check(0, 4'hF, "R8 first wake edge ignored");
    rd_check(20, 4'hF, "R8 second wake edge ignored");
    rd_check(63, 4'hF, "R8 third wake edge ignored");
    rd_check(5, 4'hF, "R8 fourth edge accepted");
    rd_check(1, 4'hF, "R9 contents kept through sleep");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule